// File: doc/BRIEF.md
# Burst External Device Write Sequencer

This block runs write cycles on an asynchronous external device bus. A stream of write entries (address, data word, byte-lane mask and an end-of-burst flag) arrives on a valid/ready request interface. For each entry the block drives the address, the data, a read/write line, a buffer direction line, a buffer enable, one chip select and two byte write enables. It times them with four delays taken from configuration inputs: chip-select delay, write-enable delay, write wait cycles and recovery (post-write) delay.

With burst mode on, consecutive entries run back to back. Chip select, write enables and buffer enable stay asserted from one write to the next. The recovery delay is spent once, after the entry flagged as last. With burst mode off, every entry is a transaction of its own and gets its own recovery delay. An external wait input can stretch a write, but only if it arrives early in the wait window. When a transaction ends, the block returns to idle and pulses `done`.

Strobe outputs are active high. Pad inversion is left to the surrounding logic. Cycle 0 of a transaction is the first clock period in which the bus shows the first entry.

Top module: `bdw_seq`

## Requirements
- R1: After reset, and whenever idle, the block holds `bus_cs` low, `bus_bwe` at 0, `bus_buf_en` low, `bus_rw_n` high, `bus_dir` low and `done` low, with `req_ready` high.
- R2: An entry accepted while idle appears on `bus_addr`/`bus_data` in the next cycle (cycle 0). From then until the transaction ends, `bus_rw_n` is low and `bus_dir` is high. `bus_buf_en` is high for that same span only if `cfg_buf_en` was set at acceptance.
- R3: `bus_cs` first asserts in cycle `cfg_cs_dly`. `bus_bwe` first becomes non-zero in cycle `cfg_we_dly` and then equals the current entry's lane mask, with bit 0 enabling the low byte (data bits 7:0) and bit 1 the high byte.
- R4: With the wait input low, each write lasts `cfg_wait_cyc` cycles (0 acts as 1). The next entry appears on the bus exactly that many cycles after the previous one, and `req_ready` is high in the last cycle of a write that has a successor.
- R5: In burst mode, `bus_cs`, `bus_bwe` and `bus_buf_en` stay asserted without a gap between writes. The burst ends with the entry whose `req_last` is 1.
- R6: After the final write, `bus_cs` and `bus_bwe` are low for `cfg_recover_cyc` cycles while `bus_rw_n` stays low. The block then goes idle and raises `done` for exactly one cycle, in the first idle cycle.
- R7: If `dev_wait` is sampled high at in-write offset k with k ≤ `cfg_wait_cyc` − 3, the wait count stops. The write ends in the cycle where `dev_wait` is sampled low, and the next entry appears in the following cycle, so the write lasts k + L + 1 cycles for a wait L cycles long.
- R8: A `dev_wait` assertion first seen at an offset later than `cfg_wait_cyc` − 3 has no effect on the write's length.
- R9: With `cfg_wait_cyc` below 3, `dev_wait` is ignored entirely.
- R10: With `cfg_burst` clear, each entry is a separate transaction with its own recovery delay and `done` pulse. The next entry can start in the `done` cycle, so entry i appears at cycle i·(`cfg_wait_cyc` + `cfg_recover_cyc` + 1).
- R11: Configuration inputs are sampled only when a transaction is accepted. Changing them during the transaction has no effect on its timing.
- R12: If a burst write ends and the next entry is not yet valid, the block holds with strobes asserted and `req_ready` high. The next entry appears in the cycle after it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_burst | input | 1 | Burst mode enable |
| cfg_buf_en | input | 1 | Allow buffer enable output |
| cfg_cs_dly | input | 4 | Chip-select delay in cycles |
| cfg_we_dly | input | 4 | Byte write enable delay in cycles |
| cfg_wait_cyc | input | 4 | Write wait cycles per write |
| cfg_recover_cyc | input | 4 | Recovery cycles after the final write |
| req_valid | input | 1 | Write entry valid |
| req_ready | output | 1 | Entry taken at this clock edge when valid |
| req_addr | input | 26 | Entry address |
| req_data | input | 16 | Entry data word |
| req_lanes | input | 2 | Entry byte-lane mask |
| req_last | input | 1 | Entry closes the burst |
| dev_wait | input | 1 | External wait, active high |
| bus_addr | output | 26 | Device address |
| bus_data | output | 16 | Device write data |
| bus_rw_n | output | 1 | Read/write line, low while writing |
| bus_dir | output | 1 | Buffer direction, high toward the device |
| bus_buf_en | output | 1 | Buffer enable, active high |
| bus_cs | output | 1 | Chip select, active high |
| bus_bwe | output | 2 | Byte write enables, active high |
| done | output | 1 | One-cycle pulse when a transaction ends |

## Verification
The assertions check several rules on every cycle. Chip select and the buffer enable only ever appear inside a write with the direction set. The bus stays quiet and ready while idle. The address and data never move without a handshake. `done` is a single-cycle pulse seen only on an idle bus. Exact timing can only be shown by the bench's scenarios, which measure it against expected values: the delay offsets, the length of each write under early, boundary, late and sub-threshold waits, the gap-free burst, the recovery length, the per-entry transactions of non-burst mode, the holds for a missing entry, and immunity to configuration changes mid-transaction.

// File: rtl/bdw_pkg.sv
// Shared types for the burst device write sequencer.
package bdw_pkg;
    // Sequencer phases: idle, write in progress, waiting for next entry, recovery.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_NEXT  = 2'd2,
        ST_POST  = 2'd3
    } seq_state_t;
endpackage

// File: rtl/bdw_wait_ctl.sv
// Per-write wait-state timer.
// Counts the cycles of the current write and tells the sequencer when the
// write is over. A wait request is honoured only if it is seen at least two
// cycles before the end of the window (so only with a window of 3 or more);
// once honoured, the count is frozen and the write ends in the cycle the wait
// input is seen low.
// Assumes op_start is high on the edge that loads a new write onto the bus.
module bdw_wait_ctl #(
    parameter int DLY_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_start,
    input  logic             op_active,
    input  logic [DLY_W-1:0] wws,
    input  logic             wait_i,
    output logic             op_end
);
    localparam int EW = DLY_W + 2;

    logic [DLY_W-1:0] wcnt;
    logic             stall;
    logic [DLY_W-1:0] last_ofs;
    logic             early;
    logic             take_wait;

    // Offset of the final cycle of the window; a zero window behaves as one.
    always_comb last_ofs = (wws == '0) ? '0 : wws - DLY_W'(1);

    // Wait is eligible when the offset leaves at least two further cycles.
    always_comb early = (EW'(wcnt) + EW'(3)) <= EW'(wws);

    // Decide whether the wait input is taken this cycle and whether the write ends.
    always_comb begin
        take_wait = op_active && !stall && early && wait_i;
        op_end    = op_active && (stall ? !wait_i : (wcnt == last_ofs));
    end

    // Offset counter and stall flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wcnt  <= '0;
            stall <= 1'b0;
        end else if (op_start) begin
            wcnt  <= '0;
            stall <= 1'b0;
        end else if (take_wait) begin
            stall <= 1'b1;
        end else if (op_active && !stall && !op_end) begin
            wcnt <= wcnt + DLY_W'(1);
        end
    end
endmodule

// File: rtl/bdw_strobe_gen.sv
// Chip-select and byte write enable timing.
// A saturating counter measures cycles since the transaction started; chip
// select and each lane's write enable turn on once their delay has passed and
// stay on for as long as run is high, so they do not drop between burst writes.
// Assumes txn_start is high on the edge that loads the first entry.
module bdw_strobe_gen #(
    parameter int DLY_W = 4,
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             txn_start,
    input  logic             run,
    input  logic [DLY_W-1:0] csd,
    input  logic [DLY_W-1:0] bwd,
    input  logic [LANES-1:0] lanes,
    output logic             cs,
    output logic [LANES-1:0] bwe
);
    localparam int CNT_W = DLY_W + 1;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] tcnt;
    logic             we_on;

    // Cycles since transaction start, held at its maximum.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tcnt <= '0;
        else if (txn_start)
            tcnt <= '0;
        else if (tcnt != CNT_MAX)
            tcnt <= tcnt + CNT_W'(1);
    end

    // Delay comparisons.
    always_comb begin
        cs    = run && (tcnt >= CNT_W'(csd));
        we_on = run && (tcnt >= CNT_W'(bwd));
    end

    // One gated enable per byte lane.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign bwe[g] = we_on && lanes[g];
    end
endmodule

// File: rtl/bdw_seq.sv
// Burst external device write sequencer (top).
// Takes write entries over valid/ready, drives them onto an asynchronous
// device bus with programmable chip-select, write-enable, wait and recovery
// timing, and in burst mode keeps strobes asserted across back-to-back writes.
// Assumes configuration is stable at the moment a transaction is accepted;
// it is captured there and ignored afterwards.
module bdw_seq #(
    parameter int ADDR_W = 26,
    parameter int DATA_W = 16,
    parameter int DLY_W  = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_burst,
    input  logic                   cfg_buf_en,
    input  logic [DLY_W-1:0]       cfg_cs_dly,
    input  logic [DLY_W-1:0]       cfg_we_dly,
    input  logic [DLY_W-1:0]       cfg_wait_cyc,
    input  logic [DLY_W-1:0]       cfg_recover_cyc,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic [DATA_W-1:0]      req_data,
    input  logic [DATA_W/8-1:0]    req_lanes,
    input  logic                   req_last,
    input  logic                   dev_wait,
    output logic [ADDR_W-1:0]      bus_addr,
    output logic [DATA_W-1:0]      bus_data,
    output logic                   bus_rw_n,
    output logic                   bus_dir,
    output logic                   bus_buf_en,
    output logic                   bus_cs,
    output logic [DATA_W/8-1:0]    bus_bwe,
    output logic                   done
);
    import bdw_pkg::*;

    localparam int LANES = DATA_W / 8;

    seq_state_t        st;
    logic [LANES-1:0]  lanes_q;
    logic              last_q;
    logic              burst_q;
    logic              buf_q;
    logic [DLY_W-1:0]  csd_q;
    logic [DLY_W-1:0]  bwd_q;
    logic [DLY_W-1:0]  wws_q;
    logic [DLY_W-1:0]  pwd_q;
    logic [DLY_W-1:0]  pcnt;
    logic              done_q;
    logic              op_end;
    logic              more;
    logic              fire;
    logic              txn_start;
    logic              in_write;
    logic              run;

    // Handshake decode: ready when idle, when holding for an entry, or when a
    // burst write is finishing and has a successor.
    always_comb begin
        more      = burst_q && !last_q;
        in_write  = (st == ST_WRITE);
        run       = (st == ST_WRITE) || (st == ST_NEXT);
        req_ready = (st == ST_IDLE) || (st == ST_NEXT) ||
                    (in_write && op_end && more);
        fire      = req_valid && req_ready;
        txn_start = fire && (st == ST_IDLE);
    end

    // Per-write wait window.
    bdw_wait_ctl #(.DLY_W(DLY_W)) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_start (fire),
        .op_active(in_write),
        .wws      (wws_q),
        .wait_i   (dev_wait),
        .op_end   (op_end)
    );

    // Chip select and byte enables.
    bdw_strobe_gen #(.DLY_W(DLY_W), .LANES(LANES)) u_strobe (
        .clk      (clk),
        .rst_n    (rst_n),
        .txn_start(txn_start),
        .run      (run),
        .csd      (csd_q),
        .bwd      (bwd_q),
        .lanes    (lanes_q),
        .cs       (bus_cs),
        .bwe      (bus_bwe)
    );

    // Capture configuration at transaction start only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            burst_q <= 1'b0;
            buf_q   <= 1'b0;
            csd_q   <= '0;
            bwd_q   <= '0;
            wws_q   <= '0;
            pwd_q   <= '0;
        end else if (txn_start) begin
            burst_q <= cfg_burst;
            buf_q   <= cfg_buf_en;
            csd_q   <= cfg_cs_dly;
            bwd_q   <= cfg_we_dly;
            wws_q   <= cfg_wait_cyc;
            pwd_q   <= cfg_recover_cyc;
        end
    end

    // Load each accepted entry onto the bus registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_addr <= '0;
            bus_data <= '0;
            lanes_q  <= '0;
            last_q   <= 1'b0;
        end else if (fire) begin
            bus_addr <= req_addr;
            bus_data <= req_data;
            lanes_q  <= req_lanes;
            last_q   <= req_last;
        end
    end

    // Phase sequencing, recovery counting and the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            pcnt   <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (fire) st <= ST_WRITE;
                end
                ST_WRITE: begin
                    if (op_end) begin
                        if (more) begin
                            if (!req_valid) st <= ST_NEXT;
                        end else if (pwd_q == '0) begin
                            st     <= ST_IDLE;
                            done_q <= 1'b1;
                        end else begin
                            st   <= ST_POST;
                            pcnt <= '0;
                        end
                    end
                end
                ST_NEXT: begin
                    if (req_valid) st <= ST_WRITE;
                end
                ST_POST: begin
                    if (pcnt == pwd_q - DLY_W'(1)) begin
                        st     <= ST_IDLE;
                        done_q <= 1'b1;
                    end else begin
                        pcnt <= pcnt + DLY_W'(1);
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Direction and buffer lines follow the busy phases.
    always_comb begin
        bus_rw_n   = (st == ST_IDLE);
        bus_dir    = (st != ST_IDLE);
        bus_buf_en = (st != ST_IDLE) && buf_q;
        done       = done_q;
    end
endmodule

// File: rtl/bdw_seq_chk.sv
// Cycle-by-cycle protocol checks for bdw_seq, attached with bind.
module bdw_seq_chk #(
    parameter int ADDR_W = 26,
    parameter int DATA_W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic                req_ready,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [DATA_W-1:0]   bus_data,
    input logic                bus_rw_n,
    input logic                bus_dir,
    input logic                bus_buf_en,
    input logic                bus_cs,
    input logic [DATA_W/8-1:0] bus_bwe,
    input logic                done
);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rw_n |-> (!bus_cs && bus_bwe == '0 && !bus_buf_en && req_ready && !bus_dir));

    // R2
    write_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rw_n |-> bus_dir);

    // R5
    cs_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cs || bus_buf_en) |-> !bus_rw_n);

    // R4
    bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rw_n && $past(!bus_rw_n) && !$past(req_valid && req_ready))
            |-> ($stable(bus_addr) && $stable(bus_data)));

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (bus_rw_n && !bus_cs && bus_bwe == '0));
endmodule

bind bdw_seq bdw_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .bus_addr  (bus_addr),
    .bus_data  (bus_data),
    .bus_rw_n  (bus_rw_n),
    .bus_dir   (bus_dir),
    .bus_buf_en(bus_buf_en),
    .bus_cs    (bus_cs),
    .bus_bwe   (bus_bwe),
    .done      (done)
);

// File: tb/bdw_seq_bench.sv
// Bench for bdw_seq: directed corners plus seeded random bursts, compared
// against timelines computed from the requirements.
module bdw_seq_bench;
    localparam int CLK_NS = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_burst = 1'b0, cfg_buf_en = 1'b0;
    logic [3:0]  cfg_cs_dly = '0, cfg_we_dly = '0, cfg_wait_cyc = '0, cfg_recover_cyc = '0;
    logic        req_valid = 1'b0, req_last = 1'b0, dev_wait = 1'b0;
    logic [25:0] req_addr = '0;
    logic [15:0] req_data = '0;
    logic [1:0]  req_lanes = '0;
    logic        req_ready, bus_rw_n, bus_dir, bus_buf_en, bus_cs, done;
    logic [25:0] bus_addr;
    logic [15:0] bus_data;
    logic [1:0]  bus_bwe;

    int n_chk = 0;
    int n_fail = 0;

    logic [25:0] e_addr [8];
    logic [15:0] e_data [8];
    logic [1:0]  e_lanes[8];

    always #(CLK_NS/2) clk = ~clk;

    bdw_seq u_bdw_seq (
        .clk(clk), .rst_n(rst_n),
        .cfg_burst(cfg_burst), .cfg_buf_en(cfg_buf_en),
        .cfg_cs_dly(cfg_cs_dly), .cfg_we_dly(cfg_we_dly),
        .cfg_wait_cyc(cfg_wait_cyc), .cfg_recover_cyc(cfg_recover_cyc),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_data(req_data), .req_lanes(req_lanes), .req_last(req_last),
        .dev_wait(dev_wait),
        .bus_addr(bus_addr), .bus_data(bus_data), .bus_rw_n(bus_rw_n),
        .bus_dir(bus_dir), .bus_buf_en(bus_buf_en), .bus_cs(bus_cs),
        .bus_bwe(bus_bwe), .done(done)
    );

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic fill(int n);
        logic [25:0] base = 26'($urandom);
        for (int i = 0; i < n; i++) begin
            e_addr[i]  = base + 26'(i * 2);
            e_data[i]  = 16'($urandom);
            e_lanes[i] = 2'($urandom_range(1, 3));
        end
    endtask

    // Expected length of write i under the single wait event (wj, wo, wl).
    function automatic int wlen(int i, int wws_e, int wj, int wo, int wl);
        if (i == wj && wl > 0 && wws_e >= 3 && wo <= wws_e - 3)
            return wo + wl + 1;
        return wws_e;
    endfunction

    // One transaction run: drive entries, measure the bus, compare with the model.
    task automatic run(string tag, int n, bit burst, bit bufe, int csd, int bwd,
                       int wws, int pwd, int wj, int wo, int wl, int hg, int hu, bit scr);
        int s_obs[8], s_exp[8], d_obs[8], b_obs[8];
        int wws_e, e_end, done_exp, first_cs, first_we, first_done;
        int cs_n, we_n, busy_n, buf_n, dones, need, idx, c;
        int cs_exp, we_exp, busy_exp, fcs_exp, fwe_exp;
        bit started, fin, fire;
        wws_e = (wws == 0) ? 1 : wws;
        for (int i = 0; i < 8; i++) begin s_obs[i] = -1; s_exp[i] = 0; d_obs[i] = 0; b_obs[i] = 0; end
        if (burst) begin
            for (int i = 1; i < n; i++) begin
                s_exp[i] = s_exp[i-1] + wlen(i-1, wws_e, wj, wo, wl);
                if (i == hg && s_exp[i] < hu + 1) s_exp[i] = hu + 1;
            end
            e_end    = s_exp[n-1] + wlen(n-1, wws_e, wj, wo, wl) - 1;
            done_exp = e_end + pwd + 1;
            cs_exp   = (csd <= e_end) ? e_end - csd + 1 : 0;
            we_exp   = (bwd <= e_end) ? e_end - bwd + 1 : 0;
            fcs_exp  = (csd <= e_end) ? csd : -1;
            fwe_exp  = (bwd <= e_end) ? bwd : -1;
            busy_exp = e_end + pwd + 1;
            need     = 1;
        end else begin
            for (int i = 0; i < n; i++) s_exp[i] = i * (wws_e + pwd + 1);
            done_exp = wws_e + pwd;
            cs_exp   = (csd < wws_e) ? n * (wws_e - csd) : 0;
            we_exp   = (bwd < wws_e) ? n * (wws_e - bwd) : 0;
            fcs_exp  = (csd < wws_e) ? csd : -1;
            fwe_exp  = (bwd < wws_e) ? bwd : -1;
            busy_exp = n * (wws_e + pwd);
            need     = n;
        end
        @(negedge clk);
        cfg_burst = burst; cfg_buf_en = bufe;
        cfg_cs_dly = 4'(csd); cfg_we_dly = 4'(bwd);
        cfg_wait_cyc = 4'(wws); cfg_recover_cyc = 4'(pwd);
        first_cs = -1; first_we = -1; first_done = -1;
        cs_n = 0; we_n = 0; busy_n = 0; buf_n = 0; dones = 0;
        idx = 0; c = -1; started = 0; fin = 0;
        for (int it = 0; it < 600; it++) begin
            if (it > 0) @(negedge clk);
            if (started) begin
                for (int i = 0; i < n; i++)
                    if (s_obs[i] < 0 && !bus_rw_n && bus_addr == e_addr[i]) begin
                        s_obs[i] = c; d_obs[i] = int'(bus_data); b_obs[i] = int'(bus_bwe);
                    end
                if (bus_cs) begin cs_n++; if (first_cs < 0) first_cs = c; end
                if (bus_bwe != 0) begin we_n++; if (first_we < 0) first_we = c; end
                if (!bus_rw_n) busy_n++;
                if (bus_buf_en) buf_n++;
                if (done) begin dones++; if (first_done < 0) first_done = c; end
                if (dones >= need) begin fin = 1; break; end
            end
            dev_wait = (wl > 0 && wj < n && s_obs[wj] >= 0 && (wj + 1 >= n || s_obs[wj+1] < 0) &&
                        c >= s_obs[wj] + wo && c < s_obs[wj] + wo + wl);
            if (scr && c == 0) begin
                cfg_burst = 1'($urandom); cfg_buf_en = ~bufe;
                cfg_cs_dly = 4'($urandom); cfg_we_dly = 4'($urandom);
                cfg_wait_cyc = 4'($urandom); cfg_recover_cyc = 4'($urandom);
            end
            if (idx < n) begin
                req_valid = !(idx == hg && c < hu);
                req_addr = e_addr[idx]; req_data = e_data[idx];
                req_lanes = e_lanes[idx]; req_last = (idx == n - 1);
            end else begin
                req_valid = 1'b0; req_last = 1'b0;
            end
            #1;
            fire = req_valid && req_ready;
            @(posedge clk);
            if (started) c++;
            if (fire && !started) begin started = 1; c = 0; end
            if (fire) idx++;
        end
        dev_wait = 1'b0; req_valid = 1'b0;
        if (!fin) chk(tag, "watchdog: transaction never ended", 0, 1);
        for (int i = 0; i < n; i++) begin
            chk(tag, $sformatf("entry %0d start cycle", i), s_obs[i], s_exp[i]);
            chk("R2", $sformatf("entry %0d data", i), d_obs[i], int'(e_data[i]));
            if (burst ? (s_exp[i] >= bwd) : (bwd == 0))
                chk("R3", $sformatf("entry %0d lanes", i), b_obs[i], int'(e_lanes[i]));
        end
        chk("R3", "first cs cycle", first_cs, fcs_exp);
        chk("R3", "first write enable cycle", first_we, fwe_exp);
        chk(burst ? "R5" : "R10", "cs cycles", cs_n, cs_exp);
        chk(burst ? "R5" : "R10", "write enable cycles", we_n, we_exp);
        chk("R6", "done cycle", first_done, done_exp);
        chk("R2", "write-busy cycles", busy_n, busy_exp);
        chk("R2", "buffer enable cycles", buf_n, bufe ? busy_exp : 0);
    endtask

    initial begin : watchdog
        #(CLK_NS * 200000);
        n_chk++; n_fail++;
        $display("FAIL all: watchdog expired actual 0 expected 1");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        void'($urandom(32'h5eed_1234));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        // R1 idle state after reset
        chk("R1", "ready after reset", int'(req_ready), 1);
        chk("R1", "cs after reset", int'(bus_cs), 0);
        chk("R1", "bwe after reset", int'(bus_bwe), 0);
        chk("R1", "rw_n after reset", int'(bus_rw_n), 1);
        chk("R1", "dir after reset", int'(bus_dir), 0);
        chk("R1", "buffer enable after reset", int'(bus_buf_en), 0);
        chk("R1", "done after reset", int'(done), 0);

        // R4 plain burst, no wait
        fill(4); run("R4", 4, 1, 1, 1, 2, 4, 2, 0, 0, 0, -1, 0, 0);
        // R7 early wait honoured
        fill(3); run("R7", 3, 1, 1, 0, 1, 5, 1, 1, 0, 3, -1, 0, 0);
        fill(3); run("R7", 3, 1, 0, 2, 0, 6, 0, 0, 1, 6, -1, 0, 0);
        // R7 boundary offset WWS-3
        fill(2); run("R7", 2, 1, 1, 1, 1, 4, 3, 0, 1, 4, -1, 0, 0);
        // R8 late wait ignored
        fill(3); run("R8", 3, 1, 1, 1, 1, 5, 2, 1, 3, 3, -1, 0, 0);
        // R9 short window ignores wait
        fill(3); run("R9", 3, 1, 1, 0, 0, 2, 1, 0, 0, 3, -1, 0, 0);
        // R10 non-burst, each entry its own transaction
        fill(3); run("R10", 3, 0, 1, 1, 2, 4, 3, 0, 0, 0, -1, 0, 0);
        fill(2); run("R10", 2, 0, 0, 0, 0, 3, 0, 0, 0, 0, -1, 0, 0);
        // R11 configuration changed mid-transaction
        fill(3); run("R11", 3, 1, 1, 2, 3, 5, 2, 0, 0, 0, -1, 0, 1);
        // R12 next entry late, block holds
        fill(4); run("R12", 4, 1, 1, 1, 1, 3, 1, 0, 0, 0, 2, 20, 0);
        // R2 buffer enable off, zero delays and zero recovery
        fill(2); run("R2", 2, 1, 0, 0, 0, 1, 0, 0, 0, 0, -1, 0, 0);

        // R7 seeded random bursts with random wait events
        for (int k = 0; k < 24; k++) begin
            int n = $urandom_range(2, 5);
            int w = $urandom_range(1, 8);
            fill(n);
            run("R7", n, 1, 1'($urandom), $urandom_range(0, 3), $urandom_range(0, 3), w,
                $urandom_range(0, 4), $urandom_range(0, n - 1), $urandom_range(0, w - 1),
                $urandom_range(0, 4), -1, 0, 1'($urandom));
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule